// File: doc/BRIEF.md
# Logical XY to pixel address converter

This block turns a logical pixel coordinate into a frame buffer location. Frame memory is a linear array of 16-bit words, and each row of the drawable surface takes a programmable number of words (the row pitch). The pitch is set apart from the visible display width, so the stored surface can be wider than what is shown. Each pixel is 1, 2, 4, 8 or 16 bits deep. The depth decides how many pixels share a word, and so it decides both the word column and the bit position of a pixel.

A drawing engine presents X, Y, a base word address, the pitch and a depth code together with a valid strobe. One clock later the block returns the 20-bit word address, the bit offset of the pixel inside that word and a mask that covers exactly the pixel's bits. The engine uses the mask for its read-modify-write of the word.

Top module: `xy_pix_addr`

## Requirements
- R1: While rst_ni is low, and after it is released with no valid input since, valid_o is 0 and addr_o, bit_o and mask_o are all 0.
- R2: valid_o is high in the cycle after a clock edge that sampled valid_i high, and low after an edge that sampled valid_i low (one cycle of latency).
- R3: addr_o = (start_i + y_i * pitch_i + ((x_i << depth_i) >> 4)) mod 2^20, where pitch_i is the row pitch in 16-bit words.
- R4: depth_i is the base-2 log of the bits per pixel: 0=1, 1=2, 2=4, 3=8, 4=16. bit_o = (x_i << depth_i) mod 16. At 16 bpp it is always 0.
- R5: mask_o has 2^depth_i consecutive ones, and its lowest set bit is at bit_o. For example, 4 bpp at offset 8 gives 16'h0F00, and 16 bpp gives 16'hFFFF.
- R6: The depth codes 5, 6 and 7 give the same addr_o, bit_o and mask_o as code 0 (1 bit per pixel).
- R7: The address sum wraps modulo 2^20. For example, start 20'hFFFF0 + 1*32 + 0 gives 20'h00010.
- R8: When valid_i is low at a clock edge, addr_o, bit_o and mask_o keep their previous values, whatever the other inputs do.
- R9: A pitch of 0 is legal and gives addr_o = start_i + ((x_i << depth_i) >> 4), independent of y_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Coordinate request strobe |
| x_i | input | 12 | Logical X |
| y_i | input | 12 | Logical Y |
| start_i | input | 20 | Base word address of the surface |
| pitch_i | input | 12 | Row pitch in 16-bit words |
| depth_i | input | 3 | log2 of bits per pixel (0..4 legal) |
| valid_o | output | 1 | Result valid |
| addr_o | output | 20 | Frame buffer word address |
| bit_o | output | 4 | Bit offset of the pixel in the word |
| mask_o | output | 16 | Pixel bit mask inside the word |

## Verification
The assertions assume that valid_i and every data input are at known levels at each sampled edge after reset. They also assume that depth_i may take any 3-bit value, with the codes 5 to 7 treated as 1 bpp. The bench drives every input on the falling edge and never leaves one undriven. It walks all five legal depths, the three illegal codes, pitch 0, the largest X and Y, and an address sum that crosses 2^20. It also includes cycles where valid_i is low and the other inputs are changed on purpose, to show that the outputs hold.

// File: rtl/xy_pix_pkg.sv
package xy_pix_pkg;
  localparam int WORD_W  = 16;
  localparam int BIT_W   = 4;
  localparam int DEPTH_W = 3;
  localparam int MAX_DEPTH = 4;

  typedef enum logic [DEPTH_W-1:0] {
    DEPTH_1  = 3'd0,
    DEPTH_2  = 3'd1,
    DEPTH_4  = 3'd2,
    DEPTH_8  = 3'd3,
    DEPTH_16 = 3'd4
  } depth_e;
endpackage

// File: rtl/xy_depth_dec.sv
module xy_depth_dec
  import xy_pix_pkg::*;
(
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DEPTH_W-1:0] shift_o,
  output logic [WORD_W-1:0]  base_mask_o
);
  logic [DEPTH_W-1:0] shift;
  logic [5:0]         bpp;

  // codes above the deepest mode fall back to 1 bpp
  assign shift   = (32'(depth_i) > MAX_DEPTH) ? DEPTH_1 : depth_i;
  assign shift_o = shift;
  assign bpp     = 6'd1 << shift;

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign base_mask_o[i] = (6'(i) < bpp);
  end
endmodule

// File: rtl/xy_row_mul.sv
module xy_row_mul #(
  parameter int Y_W     = 12,
  parameter int PITCH_W = 12,
  parameter int ADDR_W  = 20
) (
  input  logic [Y_W-1:0]     y_i,
  input  logic [PITCH_W-1:0] pitch_i,
  output logic [ADDR_W-1:0]  row_o
);
  localparam int PROD_W = Y_W + PITCH_W;
  logic [PROD_W-1:0] prod;

  assign prod  = PROD_W'(y_i) * PROD_W'(pitch_i);
  assign row_o = ADDR_W'(prod);
endmodule

// File: rtl/xy_col_split.sv
module xy_col_split
  import xy_pix_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int ADDR_W = 20
) (
  input  logic [X_W-1:0]     x_i,
  input  logic [DEPTH_W-1:0] shift_i,
  input  logic [WORD_W-1:0]  base_mask_i,
  output logic [ADDR_W-1:0]  word_o,
  output logic [BIT_W-1:0]   bit_o,
  output logic [WORD_W-1:0]  mask_o
);
  localparam int XS_W = X_W + MAX_DEPTH;
  logic [XS_W-1:0] xs;

  assign xs     = XS_W'(x_i) << shift_i;
  assign word_o = ADDR_W'(xs >> BIT_W);
  assign bit_o  = xs[BIT_W-1:0];
  assign mask_o = base_mask_i << bit_o;
endmodule

// File: rtl/xy_pix_addr.sv
module xy_pix_addr
  import xy_pix_pkg::*;
#(
  parameter int X_W     = 12,
  parameter int Y_W     = 12,
  parameter int PITCH_W = 12,
  parameter int ADDR_W  = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [X_W-1:0]     x_i,
  input  logic [Y_W-1:0]     y_i,
  input  logic [ADDR_W-1:0]  start_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [BIT_W-1:0]   bit_o,
  output logic [WORD_W-1:0]  mask_o
);
  logic [DEPTH_W-1:0] shift;
  logic [WORD_W-1:0]  base_mask, mask_d;
  logic [ADDR_W-1:0]  row_off, col_off, addr_d;
  logic [BIT_W-1:0]   bit_d;

  xy_depth_dec u_dec (
    .depth_i    (depth_i),
    .shift_o    (shift),
    .base_mask_o(base_mask)
  );

  xy_row_mul #(.Y_W(Y_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_row (
    .y_i    (y_i),
    .pitch_i(pitch_i),
    .row_o  (row_off)
  );

  xy_col_split #(.X_W(X_W), .ADDR_W(ADDR_W)) u_col (
    .x_i        (x_i),
    .shift_i    (shift),
    .base_mask_i(base_mask),
    .word_o     (col_off),
    .bit_o      (bit_d),
    .mask_o     (mask_d)
  );

  // modulo 2^ADDR_W by truncation
  assign addr_d = start_i + row_off + col_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      bit_o   <= '0;
      mask_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o <= addr_d;
        bit_o  <= bit_d;
        mask_o <= mask_d;
      end
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(addr_o) && $stable(bit_o) && $stable(mask_o)));
  // R5
  mask_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mask_o[bit_o] && $onehot0($countones(mask_o))));
  // R4
  bit_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((32'(bit_o) % $countones(mask_o)) == 0));
  // R6
  illegal_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (32'(depth_i) > MAX_DEPTH)) |=> ($countones(mask_o) == 1));
endmodule

// File: tb/xy_pix_addr_test.sv
`timescale 1ns/1ps
module xy_pix_addr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] x_i = '0, y_i = '0, pitch_i = '0;
  logic [19:0] start_i = '0;
  logic [2:0]  depth_i = '0;
  logic        valid_o;
  logic [19:0] addr_o;
  logic [3:0]  bit_o;
  logic [15:0] mask_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xy_pix_addr uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .x_i(x_i), .y_i(y_i), .start_i(start_i), .pitch_i(pitch_i),
    .depth_i(depth_i), .valid_o(valid_o), .addr_o(addr_o),
    .bit_o(bit_o), .mask_o(mask_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic model(input int x, input int y, input int s, input int p, input int d,
                       output logic [19:0] a, output logic [3:0] b, output logic [15:0] k);
    int sh, bits, bpp;
    sh   = (d > 4) ? 0 : d;
    bits = x << sh;
    bpp  = 1 << sh;
    a = 20'(s + y * p + (bits >> 4));
    b = 4'(bits % 16);
    k = 16'(((64'd1 << bpp) - 1) << b);
  endtask

  task automatic apply(input string req, input int x, input int y, input int s,
                       input int p, input int d);
    logic [19:0] ea; logic [3:0] eb; logic [15:0] ek;
    model(x, y, s, p, d, ea, eb, ek);
    @(negedge clk);
    x_i = 12'(x); y_i = 12'(y); start_i = 20'(s); pitch_i = 12'(p); depth_i = 3'(d);
    valid_i = 1'b1;
    @(negedge clk);
    chk({req, " valid (R2)"}, 32'(valid_o), 32'd1);
    chk({req, " addr"}, 32'(addr_o), 32'(ea));
    chk({req, " bit"}, 32'(bit_o), 32'(eb));
    chk({req, " mask"}, 32'(mask_o), 32'(ek));
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 bit", 32'(bit_o), 0);
    chk("R1 mask", 32'(mask_o), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 valid after release", 32'(valid_o), 0);
    chk("R1 mask after release", 32'(mask_o), 0);
  endtask

  task automatic t_depths();
    for (int d = 0; d <= 4; d++) begin
      apply("R3 R4 R5 depth", 12'h123, 5, 20'h100, 40, d);
      apply("R3 R4 R5 depth odd x", 37, 9, 20'h3000, 100, d);
    end
    apply("R4 16bpp max x", 4095, 0, 0, 0, 4);
    chk("R4 16bpp bit zero", 32'(bit_o), 0);
    chk("R5 16bpp mask", 32'(mask_o), 32'hFFFF);
    apply("R5 4bpp offset 8", 2, 0, 0, 0, 2);
    chk("R5 4bpp mask literal", 32'(mask_o), 32'h0F00);
  endtask

  task automatic t_illegal();
    for (int d = 5; d <= 7; d++) begin
      apply("R6 illegal code", 37, 3, 20'h50, 12, d);
      chk("R6 mask as 1bpp", 32'(mask_o), 32'h0020);
    end
  endtask

  task automatic t_wrap();
    apply("R7 wrap", 0, 1, 20'hFFFF0, 32, 0);
    chk("R7 wrap literal", 32'(addr_o), 32'h00010);
    apply("R7 wrap max", 4095, 4095, 20'hFFFFF, 4095, 4);
  endtask

  task automatic t_pitch_zero();
    apply("R9 pitch zero", 100, 4000, 20'h777, 0, 3);
    chk("R9 pitch zero literal", 32'(addr_o), 32'h777 + 50);
  endtask

  task automatic t_hold();
    logic [19:0] a0; logic [3:0] b0; logic [15:0] m0;
    apply("R8 setup", 21, 7, 20'h1234, 64, 1);
    a0 = addr_o; b0 = bit_o; m0 = mask_o;
    x_i = 12'd999; y_i = 12'd888; start_i = 20'hABCDE; pitch_i = 12'd77; depth_i = 3'd4;
    @(negedge clk);
    chk("R2 valid low", 32'(valid_o), 0);
    @(negedge clk);
    chk("R8 addr held", 32'(addr_o), 32'(a0));
    chk("R8 bit held", 32'(bit_o), 32'(b0));
    chk("R8 mask held", 32'(mask_o), 32'(m0));
  endtask

  initial begin
    t_reset();
    t_depths();
    t_illegal();
    t_wrap();
    t_pitch_zero();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule